// File: doc/BRIEF.md
# Multi-Queue Receive Descriptor Ring Engine

This block moves received frames into system memory. Software builds up to four circular rings of receive descriptors in memory and gives each ring a head pointer through the register port. A frame arrives on a framed byte input and is first held whole in a small internal buffer, so its length is known before any placement decision. The engine then walks the rings in fixed queue order and takes the first descriptor that hardware owns and whose buffer can hold the frame. It copies the bytes into that buffer through its memory master, reports the stored length, hands the descriptor back to software and moves that queue's live pointer to the next descriptor.

Each descriptor is four little-endian 32-bit words at increasing addresses. Word 0 is command/status, with the ownership flag in bit 31 (1 = owned by hardware). Word 1 carries the received byte count in bits 15:0 and the buffer capacity in bits 31:16. Word 2 is the buffer base address, and word 3 points at the next descriptor. An optional 2-byte lead-in shifts where the data lands and is included in the reported count. Each completion sets a cause flag that is gated by a mask to drive a level interrupt. A frame that fits no descriptor is discarded.

Top module: `rxr_engine`

## Requirements
- R1: After reset, irq is 0, in_ready is 1, and every register reads as 0.
- R2: A write to ring-head register q (address 0x10 + 4q) loads both the head and the live current pointer of queue q, and a read returns the head. The four registers at 0x20 + 4q are plain read/write pointer storage.
- R3: Queues are tried in order 0, 1, 2, 3. A queue whose current pointer is zero is skipped, and the first suitable descriptor found receives the frame.
- R4: Within a queue the walk starts at the current pointer and follows word 3. It leaves the queue when the next pointer equals that queue's head.
- R5: A descriptor is suitable only when word 0 bit 31 is 1 and the capacity in word 1 bits 31:16 is at least the frame length. Equality is accepted.
- R6: Frame bytes are written from buffer base + offset. The offset is 2 when bit 0 of the control register (0x00) is 1, else 0. Word 1 bits 15:0 become length + offset, and bits 31:16 are kept.
- R7: On acceptance, word 0 bit 31 is cleared while its other bits are kept, and the queue's current pointer takes that descriptor's next pointer. The following frame therefore goes to the next descriptor.
- R8: Each acceptance sets bit 0 of the cause register (0x04). irq is 1 while cause bit 0 and mask bit 0 (0x08) are both 1.
- R9: A write to the cause register ANDs the written value into it. A write to the mask register that enables a pending cause raises irq.
- R10: A frame with no suitable descriptor is dropped. Memory and the cause register are left unchanged.
- R11: in_ready is 0 from the cycle after a frame's last byte is accepted until the frame has been placed or dropped. No memory access occurs while in_ready is 1.
- R12: A frame longer than FRAME_BYTES is dropped whole. A frame of exactly FRAME_BYTES is placed.
- R13: A queue whose walk does not return to its head is abandoned after MAX_WALK descriptors, and the search moves on to the next queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Marks the final byte of a frame |
| in_ready | output | 1 | Engine accepts an input byte |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_byte | output | 1 | 1 = byte write in mem_wdata[7:0], 0 = 32-bit word |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Access completes this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| irq | output | 1 | Level receive interrupt |

## Verification
On every cycle the assertions check four things. No memory access overlaps input acceptance. Only an owned, large-enough descriptor is handed back. The cause flag rises only after a completion, and a walk that exceeds its bound leaves the queue. The order in which queues are chosen, the byte placement with and without the lead-in offset, and the advance of the live pointer depend on memory contents, so only the bench scenarios show them. The same holds for the silent drop and the overflow drop.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

    localparam int NQ      = 4;
    localparam int QW      = $clog2(NQ);
    localparam int OWN_BIT = 31;
    localparam int LEN_W   = 16;

    localparam logic [7:0] REG_CTRL   = 8'h00;
    localparam logic [7:0] REG_CAUSE  = 8'h04;
    localparam logic [7:0] REG_MASK   = 8'h08;
    localparam logic [7:0] REG_HEAD0  = 8'h10;
    localparam logic [7:0] REG_FIRST0 = 8'h20;

    typedef enum logic [3:0] {
        S_IDLE, S_QSEL, S_RD_CMD, S_RD_LEN, S_RD_BUF, S_RD_NXT,
        S_CHECK, S_DATA, S_WB_LEN, S_WB_CMD
    } rx_state_e;

    typedef struct packed {
        logic [31:0]      cmd;
        logic [LEN_W-1:0] size;
        logic [31:0]      buf_addr;
        logic [31:0]      next;
    } rx_desc_t;

    function automatic logic desc_fits(rx_desc_t d, logic [LEN_W-1:0] len);
        return d.cmd[OWN_BIT] && (d.size >= len);
    endfunction

endpackage

// File: rtl/rxr_regs.sv
module rxr_regs
    import rxr_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  reg_wr,
    input  logic [7:0]            reg_addr,
    input  logic [31:0]           reg_wdata,
    output logic [31:0]           reg_rdata,
    output logic                  prefix_en,
    output logic [NQ-1:0][31:0]   head,
    output logic [NQ-1:0][31:0]   cur,
    input  logic                  adv_en,
    input  logic [QW-1:0]         adv_q,
    input  logic [31:0]           adv_ptr,
    input  logic                  rx_evt,
    output logic                  irq
);

    logic [NQ-1:0][31:0] first_q;
    logic                cause_q;
    logic                mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            head      <= '0;
            cur       <= '0;
            first_q   <= '0;
            prefix_en <= 1'b0;
            mask_q    <= 1'b0;
        end else begin
            if (adv_en) cur[adv_q] <= adv_ptr;
            if (reg_wr) begin
                if (reg_addr == REG_CTRL) prefix_en <= reg_wdata[0];
                if (reg_addr == REG_MASK) mask_q    <= reg_wdata[0];
                for (int k = 0; k < NQ; k++) begin
                    if (reg_addr == REG_HEAD0 + 8'(4 * k)) begin
                        head[k] <= reg_wdata;
                        cur[k]  <= reg_wdata;
                    end
                    if (reg_addr == REG_FIRST0 + 8'(4 * k)) first_q[k] <= reg_wdata;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cause_q <= 1'b0;
        end else if (rx_evt) begin
            cause_q <= 1'b1;
        end else if (reg_wr && reg_addr == REG_CAUSE) begin
            cause_q <= cause_q & reg_wdata[0];
        end
    end

    assign irq = cause_q & mask_q;

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            REG_CTRL:  reg_rdata[0] = prefix_en;
            REG_CAUSE: reg_rdata[0] = cause_q;
            REG_MASK:  reg_rdata[0] = mask_q;
            default:   reg_rdata = '0;
        endcase
        for (int k = 0; k < NQ; k++) begin
            if (reg_addr == REG_HEAD0 + 8'(4 * k))  reg_rdata = head[k];
            if (reg_addr == REG_FIRST0 + 8'(4 * k)) reg_rdata = first_q[k];
        end
    end

    AST_CAUSE_SOURCE: assert property (@(posedge clk) disable iff (rst)
        $rose(cause_q) |-> $past(rx_evt));  // R8

    AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (rst)
        (rx_evt && mask_q && !(reg_wr && reg_addr == REG_MASK)) |=> irq);  // R8

endmodule

// File: rtl/rxr_frame_buf.sv
module rxr_frame_buf
    import rxr_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    input  logic             in_last,
    output logic             in_ready,
    input  logic             busy,
    input  logic [IW-1:0]    rd_idx,
    output logic [7:0]       rd_byte,
    output logic             frm_rdy,
    output logic [LEN_W-1:0] frm_len,
    output logic             frm_ovf
);

    logic [7:0]       store [DEPTH];
    logic [LEN_W-1:0] cnt_q;
    logic             ovf_q;
    logic             accept;
    logic             room;

    assign in_ready = !busy && !frm_rdy;
    assign accept   = in_valid && in_ready;
    assign room     = cnt_q < LEN_W'(DEPTH);
    assign rd_byte  = store[rd_idx];

    always_ff @(posedge clk) begin
        if (accept && room) store[cnt_q[IW-1:0]] <= in_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            ovf_q   <= 1'b0;
            frm_rdy <= 1'b0;
            frm_len <= '0;
            frm_ovf <= 1'b0;
        end else begin
            frm_rdy <= 1'b0;
            if (accept) begin
                if (in_last) begin
                    frm_rdy <= 1'b1;
                    frm_len <= cnt_q + 1'b1;
                    frm_ovf <= ovf_q || !room;
                    cnt_q   <= '0;
                    ovf_q   <= 1'b0;
                end else if (room) begin
                    cnt_q <= cnt_q + 1'b1;
                end else begin
                    ovf_q <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/rxr_placer.sv
module rxr_placer
    import rxr_pkg::*;
#(
    parameter int DEPTH    = 64,
    parameter int MAX_WALK = 16,
    localparam int IW      = $clog2(DEPTH),
    localparam int HW      = $clog2(MAX_WALK + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                frm_rdy,
    input  logic [LEN_W-1:0]    frm_len,
    input  logic                frm_ovf,
    output logic [IW-1:0]       fb_idx,
    input  logic [7:0]          fb_byte,
    input  logic                prefix_en,
    input  logic [NQ-1:0][31:0] head,
    input  logic [NQ-1:0][31:0] cur,
    output logic                adv_en,
    output logic [QW-1:0]       adv_q,
    output logic [31:0]         adv_ptr,
    output logic                rx_evt,
    output logic                busy,
    output logic                mem_req,
    output logic                mem_we,
    output logic                mem_byte,
    output logic [31:0]         mem_addr,
    output logic [31:0]         mem_wdata,
    input  logic                mem_ready,
    input  logic [31:0]         mem_rdata
);

    rx_state_e        st;
    rx_desc_t         desc_q;
    logic [31:0]      addr_q;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] idx_q;
    logic [1:0]       off_q;
    logic [QW-1:0]    q_q;
    logic [HW-1:0]    hops_q;
    logic             fits;
    logic             ring_done;
    logic             last_q;

    assign fits      = desc_fits(desc_q, len_q);
    assign ring_done = (desc_q.next == head[q_q]) || (hops_q == HW'(MAX_WALK - 1));
    assign last_q    = (q_q == QW'(NQ - 1));
    assign busy      = (st != S_IDLE);
    assign fb_idx    = idx_q[IW-1:0];
    assign adv_en    = (st == S_WB_CMD) && mem_ready;
    assign rx_evt    = adv_en;
    assign adv_q     = q_q;
    assign adv_ptr   = desc_q.next;

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_byte  = 1'b0;
        mem_addr  = addr_q;
        mem_wdata = '0;
        case (st)
            S_RD_CMD: mem_req = 1'b1;
            S_RD_LEN: begin mem_req = 1'b1; mem_addr = addr_q + 32'd4;  end
            S_RD_BUF: begin mem_req = 1'b1; mem_addr = addr_q + 32'd8;  end
            S_RD_NXT: begin mem_req = 1'b1; mem_addr = addr_q + 32'd12; end
            S_DATA: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_byte  = 1'b1;
                mem_addr  = desc_q.buf_addr + 32'(off_q) + 32'(idx_q);
                mem_wdata = {24'b0, fb_byte};
            end
            S_WB_LEN: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = addr_q + 32'd4;
                mem_wdata = {desc_q.size, len_q + LEN_W'(off_q)};
            end
            S_WB_CMD: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = desc_q.cmd & ~(32'd1 << OWN_BIT);
            end
            default: mem_req = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= S_IDLE;
            desc_q <= '0;
            addr_q <= '0;
            len_q  <= '0;
            idx_q  <= '0;
            off_q  <= '0;
            q_q    <= '0;
            hops_q <= '0;
        end else begin
            case (st)
                S_IDLE: if (frm_rdy && !frm_ovf) begin
                    len_q <= frm_len;
                    off_q <= prefix_en ? 2'd2 : 2'd0;
                    q_q   <= '0;
                    st    <= S_QSEL;
                end
                S_QSEL: begin
                    if (cur[q_q] == '0) begin
                        if (last_q) st <= S_IDLE;
                        else q_q <= q_q + 1'b1;
                    end else begin
                        addr_q <= cur[q_q];
                        hops_q <= '0;
                        st     <= S_RD_CMD;
                    end
                end
                S_RD_CMD: if (mem_ready) begin desc_q.cmd      <= mem_rdata;         st <= S_RD_LEN; end
                S_RD_LEN: if (mem_ready) begin desc_q.size     <= mem_rdata[31:16];  st <= S_RD_BUF; end
                S_RD_BUF: if (mem_ready) begin desc_q.buf_addr <= mem_rdata;         st <= S_RD_NXT; end
                S_RD_NXT: if (mem_ready) begin desc_q.next     <= mem_rdata;         st <= S_CHECK;  end
                S_CHECK: begin
                    if (fits) begin
                        idx_q <= '0;
                        st    <= S_DATA;
                    end else if (ring_done) begin
                        if (last_q) st <= S_IDLE;
                        else begin
                            q_q <= q_q + 1'b1;
                            st  <= S_QSEL;
                        end
                    end else begin
                        addr_q <= desc_q.next;
                        hops_q <= hops_q + 1'b1;
                        st     <= S_RD_CMD;
                    end
                end
                S_DATA: if (mem_ready) begin
                    if (idx_q == len_q - 1'b1) st <= S_WB_LEN;
                    else idx_q <= idx_q + 1'b1;
                end
                S_WB_LEN: if (mem_ready) st <= S_WB_CMD;
                S_WB_CMD: if (mem_ready) st <= S_IDLE;
                default:  st <= S_IDLE;
            endcase
        end
    end

    AST_ACCEPT_OWNED: assert property (@(posedge clk) disable iff (rst)
        adv_en |-> (desc_q.cmd[OWN_BIT] && desc_q.size >= len_q));  // R5

    AST_WALK_LIMIT: assert property (@(posedge clk) disable iff (rst)
        (st == S_CHECK && !fits && hops_q == HW'(MAX_WALK - 1))
        |=> (st == S_QSEL || st == S_IDLE));  // R13

endmodule

// File: rtl/rxr_engine.sv
module rxr_engine
    import rxr_pkg::*;
#(
    parameter int FRAME_BYTES = 64,
    parameter int MAX_WALK    = 16,
    localparam int IW         = $clog2(FRAME_BYTES)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [7:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        in_valid,
    input  logic [7:0]  in_data,
    input  logic        in_last,
    output logic        in_ready,
    output logic        mem_req,
    output logic        mem_we,
    output logic        mem_byte,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_ready,
    input  logic [31:0] mem_rdata,
    output logic        irq
);

    logic                prefix_en;
    logic [NQ-1:0][31:0] head;
    logic [NQ-1:0][31:0] cur;
    logic                adv_en;
    logic [QW-1:0]       adv_q;
    logic [31:0]         adv_ptr;
    logic                rx_evt;
    logic                busy;
    logic [IW-1:0]       fb_idx;
    logic [7:0]          fb_byte;
    logic                frm_rdy;
    logic [LEN_W-1:0]    frm_len;
    logic                frm_ovf;

    rxr_regs u_regs (
        .clk, .rst, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
        .prefix_en, .head, .cur, .adv_en, .adv_q, .adv_ptr, .rx_evt, .irq
    );

    rxr_frame_buf #(.DEPTH(FRAME_BYTES)) u_fbuf (
        .clk, .rst, .in_valid, .in_data, .in_last, .in_ready, .busy,
        .rd_idx(fb_idx), .rd_byte(fb_byte), .frm_rdy, .frm_len, .frm_ovf
    );

    rxr_placer #(.DEPTH(FRAME_BYTES), .MAX_WALK(MAX_WALK)) u_place (
        .clk, .rst, .frm_rdy, .frm_len, .frm_ovf, .fb_idx, .fb_byte,
        .prefix_en, .head, .cur, .adv_en, .adv_q, .adv_ptr, .rx_evt, .busy,
        .mem_req, .mem_we, .mem_byte, .mem_addr, .mem_wdata, .mem_ready, .mem_rdata
    );

    AST_NO_MEM_WHILE_RX: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !in_ready);  // R11

endmodule

// File: tb/rxr_engine_tb_top.sv
`timescale 1ns/1ps
module rxr_engine_tb_top;

    localparam int FB = 32;
    localparam int MW = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_last = 1'b0;
    logic        in_ready;
    logic        mem_req, mem_we, mem_byte;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_ready;
    logic        irq;
    logic [1:0]  stall = '0;
    logic [7:0]  bm [0:4095];
    int          n_chk = 0;
    int          n_err = 0;
    logic        done = 1'b0;

    always #2.5 clk = ~clk;

    rxr_engine #(.FRAME_BYTES(FB), .MAX_WALK(MW)) dut_i (
        .clk, .rst, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
        .in_valid, .in_data, .in_last, .in_ready,
        .mem_req, .mem_we, .mem_byte, .mem_addr, .mem_wdata, .mem_ready, .mem_rdata, .irq
    );

    // memory model: ready stalls one cycle in four
    always @(posedge clk) stall <= stall + 2'd1;
    assign mem_ready = (stall != 2'd0);
    assign mem_rdata = {bm[mem_addr[11:0] + 12'd3], bm[mem_addr[11:0] + 12'd2],
                        bm[mem_addr[11:0] + 12'd1], bm[mem_addr[11:0]]};
    always @(posedge clk) begin
        if (mem_req && mem_we && mem_ready) begin
            if (mem_byte) bm[mem_addr[11:0]] = mem_wdata[7:0];
            else for (int b = 0; b < 4; b++) bm[mem_addr[11:0] + 12'(b)] = mem_wdata[8*b +: 8];
        end
    end

    localparam logic [31:0] DA = 32'h100, DB = 32'h110, DC = 32'h120, DD = 32'h130;
    localparam logic [31:0] DE = 32'h140, DF = 32'h150, DG = 32'h160;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] rdw(logic [31:0] a);
        return {bm[a + 3], bm[a + 2], bm[a + 1], bm[a]};
    endfunction

    task automatic wrw(logic [31:0] a, logic [31:0] v);
        for (int b = 0; b < 4; b++) bm[a + 32'(b)] = v[8*b +: 8];
    endtask

    task automatic put_desc(logic [31:0] a, logic [31:0] cmd, logic [15:0] size,
                            logic [31:0] bufa, logic [31:0] nxt);
        wrw(a, cmd);
        wrw(a + 4, {size, 16'h0});
        wrw(a + 8, bufa);
        wrw(a + 12, nxt);
    endtask

    task automatic reg_write(logic [7:0] a, logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic send_frame(int n, logic [7:0] seed);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_data = seed + 8'(i); in_last = (i == n - 1);
            while (!in_ready) @(negedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
        chk("R11 in_ready low after last byte", {31'b0, in_ready}, 32'd0);
        for (int i = 0; i < 3000; i++) begin
            if (in_ready) break;
            @(negedge clk);
        end
        @(negedge clk);
    endtask

    task automatic chk_bytes(string req, logic [31:0] a, int n, logic [7:0] seed);
        for (int i = 0; i < n; i++) chk(req, {24'b0, bm[a + 32'(i)]}, {24'b0, seed + 8'(i)});
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 irq", {31'b0, irq}, 32'd0);
        chk("R1 in_ready", {31'b0, in_ready}, 32'd1);
        reg_read(8'h04, v); chk("R1 cause", v, 32'd0);
        reg_read(8'h10, v); chk("R1 head0", v, 32'd0);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        reg_write(8'h24, 32'hCAFE_0004);
        reg_read(8'h24, v); chk("R2 first ptr", v, 32'hCAFE_0004);
        reg_write(8'h1C, 32'h0000_0ABC);
        reg_read(8'h1C, v); chk("R2 head3", v, 32'h0000_0ABC);
        reg_write(8'h1C, 32'h0);
    endtask

    task automatic t_basic();
        logic [31:0] v;
        put_desc(DA, 32'h8000_00A5, 16'd64, 32'h400, DB);
        put_desc(DB, 32'h8000_0011, 16'd64, 32'h500, DA);
        reg_write(8'h10, DA);
        send_frame(5, 8'h30);
        chk_bytes("R6 data at buffer", 32'h400, 5, 8'h30);
        chk("R7 own cleared", rdw(DA), 32'h0000_00A5);
        chk("R6 count field", rdw(DA + 4), 32'h0040_0005);
        reg_read(8'h04, v); chk("R8 cause set", v, 32'd1);
        chk("R8 irq masked off", {31'b0, irq}, 32'd0);
        reg_write(8'h08, 32'd1);
        chk("R9 mask write raises irq", {31'b0, irq}, 32'd1);
        reg_write(8'h04, 32'd0);
        chk("R9 cause cleared by write", {31'b0, irq}, 32'd0);
        send_frame(4, 8'h50);
        chk("R7 next descriptor used", rdw(DB), 32'h0000_0011);
        chk("R7 next count", rdw(DB + 4), 32'h0040_0004);
        chk_bytes("R7 next data", 32'h500, 4, 8'h50);
        chk("R8 irq after rx", {31'b0, irq}, 32'd1);
        reg_write(8'h04, 32'd0);
    endtask

    task automatic t_offset();
        put_desc(DA, 32'h8000_0000, 16'd64, 32'h400, DB);
        for (int i = 0; i < 8; i++) bm[32'h400 + 32'(i)] = 8'h00;
        reg_write(8'h00, 32'd1);
        reg_write(8'h10, DA);
        send_frame(3, 8'h70);
        chk("R6 lead-in untouched", rdw(32'h400) & 32'h0000_FFFF, 32'd0);
        chk_bytes("R6 offset data", 32'h402, 3, 8'h70);
        chk("R6 count includes offset", rdw(DA + 4), 32'h0040_0005);
        reg_write(8'h00, 32'd0);
        reg_write(8'h04, 32'd0);
    endtask

    task automatic t_size();
        put_desc(DA, 32'h8000_0000, 16'd4, 32'h400, DB);
        put_desc(DB, 32'h8000_0000, 16'd64, 32'h500, DA);
        reg_write(8'h10, DA);
        send_frame(6, 8'h90);
        chk("R5 small buffer skipped", rdw(DA), 32'h8000_0000);
        chk("R5 larger buffer taken", rdw(DB + 4), 32'h0040_0006);
        send_frame(4, 8'hA0);
        chk("R5 exact fit accepted", rdw(DA + 4), 32'h0004_0004);
        chk("R5 exact fit own", rdw(DA), 32'h0000_0000);
        reg_write(8'h04, 32'd0);
    endtask

    task automatic t_order();
        put_desc(DC, 32'h8000_0000, 16'd64, 32'h600, DC);
        put_desc(DD, 32'h8000_0000, 16'd64, 32'h700, DD);
        reg_write(8'h10, 32'h0);
        reg_write(8'h14, DC);
        reg_write(8'h18, DD);
        send_frame(2, 8'hC0);
        chk("R3 zero queue skipped, q1 taken", rdw(DC), 32'h0);
        chk("R3 q2 untouched", rdw(DD), 32'h8000_0000);
        put_desc(DA, 32'h0, 16'd64, 32'h400, DA);
        reg_write(8'h10, DA);
        send_frame(2, 8'hD0);
        chk("R4 unowned ring left, q2 taken", rdw(DD + 4), 32'h0040_0002);
        chk_bytes("R4 q2 data", 32'h700, 2, 8'hD0);
        reg_write(8'h04, 32'd0);
    endtask

    task automatic t_drop();
        logic [31:0] v;
        send_frame(3, 8'hB0);
        reg_read(8'h04, v); chk("R10 cause unchanged", v, 32'd0);
        chk("R10 descriptor unchanged", rdw(DD + 4), 32'h0040_0002);
        chk_bytes("R10 buffer unchanged", 32'h700, 2, 8'hD0);
    endtask

    task automatic t_walk();
        put_desc(DE, 32'h0, 16'd64, 32'h900, DF);
        put_desc(DF, 32'h0, 16'd64, 32'h900, DF);
        put_desc(DG, 32'h8000_0003, 16'd64, 32'h800, DG);
        reg_write(8'h10, DE);
        reg_write(8'h14, DG);
        send_frame(3, 8'hE0);
        chk("R13 bounded walk, q1 own", rdw(DG), 32'h0000_0003);
        chk("R13 bounded walk, q1 count", rdw(DG + 4), 32'h0040_0003);
        reg_write(8'h04, 32'd0);
    endtask

    task automatic t_overflow();
        logic [31:0] v;
        put_desc(DG, 32'h8000_0000, 16'd64, 32'h800, DG);
        reg_write(8'h10, 32'h0);
        reg_write(8'h14, DG);
        send_frame(FB + 8, 8'h10);
        chk("R12 long frame dropped", rdw(DG), 32'h8000_0000);
        reg_read(8'h04, v); chk("R12 no cause on drop", v, 32'd0);
        send_frame(FB, 8'h20);
        chk("R12 full-size frame count", rdw(DG + 4), 32'h0040_0020);
        chk_bytes("R12 full-size data", 32'h800, FB, 8'h20);
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) bm[i] = 8'h00;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_regs();
        t_basic();
        t_offset();
        t_size();
        t_order();
        t_drop();
        t_walk();
        t_overflow();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule